// File: doc/BRIEF.md
# Video Automatic Gain Controller

This block closes the digital gain loop for one digitized video channel. It holds a 4-bit coarse gain code and a 12-bit fine gain word. The two form a 16-bit combined gain `{coarse, fine}`. Coarse code 0x0 is the weakest setting: -6 dB, about 2 Vpp at full scale. Code 0xF is the strongest: +6 dB, about 0.5 Vpp at full scale. The loop aims to let the 10-bit converter swing over its whole range without clipping.

Once per video line a measurement stage presents four amplitude readings: sync height, colour burst amplitude, composite peak and luma peak. It then pulses `line_done` for one cycle. Each reading is compared with its own limit, and a 4-bit mask selects which readings take part.

- **Overload:** if any selected reading is above its limit, gain drops by one coarse code on that same line.
- **Clean line:** the hold-off counter advances. Once it has counted the programmed number of clean lines, each further clean line raises the combined gain by a programmed step.

When the loop is disabled, the gain follows two host-written manual values. Enabling the loop resumes from that manual setting. The gain in use is always visible on the gain outputs.

Top module: `vagc_loop`

## Requirements
- R1: While `rst_n` is low, `gain_coarse` reads 0x0 and `gain_fine` reads 0x000.
- R2: While `loop_en` is low, `gain_coarse`/`gain_fine` take the values of `man_coarse`/`man_fine` one clock later, and the hold-off counter is cleared.
- R3: With `loop_en` high, the gain changes only on a clock where `line_done` is high.
- R4: Mask bit 0 selects sync height, bit 1 burst amplitude, bit 2 composite peak, bit 3 luma peak. A reading counts as an overload only if its mask bit is 1 and the reading is strictly greater than its limit.
- R5: On a `line_done` with an overload, the combined gain falls by 0x1000, saturating at 0x0000, and the hold-off counter returns to zero.
- R6: With hold-off value D, the first D clean lines after an overload or after enabling leave the gain unchanged; each clean line after that raises it.
- R7: A raise adds `rise_step` to the combined gain. A carry out of the fine word increments the coarse code, and the combined gain saturates at 0xFFFF.
- R8: A `line_done` with an all-zero mask changes neither the gain nor the hold-off counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loop_en | input | 1 | 1 = automatic loop, 0 = manual gain |
| line_done | input | 1 | One-cycle strobe: the measurements of a line are valid |
| ref_mask | input | 4 | Reference select (bit0 sync, bit1 burst, bit2 composite peak, bit3 luma peak) |
| meas_sync | input | 10 | Measured sync height |
| meas_burst | input | 10 | Measured burst amplitude |
| meas_cpeak | input | 10 | Measured composite peak |
| meas_lpeak | input | 10 | Measured luma peak |
| lim_sync | input | 10 | Overload limit for sync height |
| lim_burst | input | 10 | Overload limit for burst amplitude |
| lim_cpeak | input | 10 | Overload limit for composite peak |
| lim_lpeak | input | 10 | Overload limit for luma peak |
| rise_step | input | 12 | Amount added per raise |
| rise_delay | input | 8 | Clean lines required before raising |
| man_coarse | input | 4 | Manual coarse code |
| man_fine | input | 12 | Manual fine word |
| gain_coarse | output | 4 | Coarse code in use |
| gain_fine | output | 12 | Fine word in use |

## Verification
The hardest states to reach are the carry from fine into coarse and the two saturation points. Reaching them by stepping the loop from reset would take thousands of lines. The stimulus instead parks the gain near each boundary through the manual path with the loop disabled. It then enables the loop with a zero hold-off, so that a single clean or overloaded line crosses the boundary. The hold-off reset is exposed by placing a clean line directly after an overload and checking that the gain does not move.

// File: rtl/vagc_pkg.sv
package vagc_pkg;
  localparam int COARSE_W = 4;
  localparam int FINE_W   = 12;
  localparam int GAIN_W   = COARSE_W + FINE_W;
  localparam int MEAS_W   = 10;
  localparam int NREF     = 4;

  typedef logic [GAIN_W-1:0] gain_t;

  // index of each amplitude reference inside the mask
  typedef enum logic [1:0] {
    REF_SYNC  = 2'd0,
    REF_BURST = 2'd1,
    REF_CPEAK = 2'd2,
    REF_LPEAK = 2'd3
  } ref_idx_e;

  // one coarse code down, clamped at the bottom
  function automatic gain_t gain_cut(input gain_t g);
    gain_t one_code;
    one_code = gain_t'(1) << FINE_W;
    if (g >= one_code) return g - one_code;
    return '0;
  endfunction

  // add a step, clamped at the top
  function automatic gain_t gain_raise(input gain_t g, input logic [FINE_W-1:0] step);
    logic [GAIN_W:0] sum;
    sum = {1'b0, g} + {{(GAIN_W+1-FINE_W){1'b0}}, step};
    if (sum[GAIN_W]) return '1;
    return sum[GAIN_W-1:0];
  endfunction
endpackage

// File: rtl/vagc_judge.sv
module vagc_judge
  import vagc_pkg::*;
#(
  parameter int N = NREF,
  parameter int W = MEAS_W
) (
  input  logic [N-1:0]        mask,
  input  logic [N-1:0][W-1:0] meas,
  input  logic [N-1:0][W-1:0] lim,
  output logic                over,
  output logic                clean
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = mask[i] && (meas[i] > lim[i]);
  end

  assign over  = |hit;
  assign clean = (|mask) && !over;
endmodule

// File: rtl/vagc_holdoff.sv
module vagc_holdoff #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             clean_line,
  input  logic [DLY_W-1:0] delay,
  output logic             rise_ok,
  output logic             waiting,
  output logic [DLY_W-1:0] count
);
  logic [DLY_W-1:0] cnt_q;

  assign rise_ok = clean_line && (cnt_q >= delay);
  assign waiting = clean_line && !rise_ok;
  assign count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (waiting) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vagc_gain_reg.sv
module vagc_gain_reg
  import vagc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_man,
  input  gain_t             man_gain,
  input  logic              cut,
  input  logic              rise,
  input  logic [FINE_W-1:0] step,
  output gain_t             gain
);
  gain_t gain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gain_q <= '0;
    else if (load_man) gain_q <= man_gain;
    else if (cut)      gain_q <= gain_cut(gain_q);
    else if (rise)     gain_q <= gain_raise(gain_q, step);
  end

  assign gain = gain_q;
endmodule

// File: rtl/vagc_loop.sv
module vagc_loop
  import vagc_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                loop_en,
  input  logic                line_done,
  input  logic [NREF-1:0]     ref_mask,
  input  logic [MEAS_W-1:0]   meas_sync,
  input  logic [MEAS_W-1:0]   meas_burst,
  input  logic [MEAS_W-1:0]   meas_cpeak,
  input  logic [MEAS_W-1:0]   meas_lpeak,
  input  logic [MEAS_W-1:0]   lim_sync,
  input  logic [MEAS_W-1:0]   lim_burst,
  input  logic [MEAS_W-1:0]   lim_cpeak,
  input  logic [MEAS_W-1:0]   lim_lpeak,
  input  logic [FINE_W-1:0]   rise_step,
  input  logic [DLY_W-1:0]    rise_delay,
  input  logic [COARSE_W-1:0] man_coarse,
  input  logic [FINE_W-1:0]   man_fine,
  output logic [COARSE_W-1:0] gain_coarse,
  output logic [FINE_W-1:0]   gain_fine
);
  logic [NREF-1:0][MEAS_W-1:0] meas_v, lim_v;
  logic  is_over, is_clean;
  logic  over_ev, clean_ev, rise_ev, hold_ev;
  logic  [DLY_W-1:0] hold_cnt;
  gain_t gain_now;

  assign meas_v[REF_SYNC]  = meas_sync;
  assign meas_v[REF_BURST] = meas_burst;
  assign meas_v[REF_CPEAK] = meas_cpeak;
  assign meas_v[REF_LPEAK] = meas_lpeak;
  assign lim_v[REF_SYNC]   = lim_sync;
  assign lim_v[REF_BURST]  = lim_burst;
  assign lim_v[REF_CPEAK]  = lim_cpeak;
  assign lim_v[REF_LPEAK]  = lim_lpeak;

  vagc_judge #(.N(NREF), .W(MEAS_W)) u_judge (
    .mask  (ref_mask),
    .meas  (meas_v),
    .lim   (lim_v),
    .over  (is_over),
    .clean (is_clean)
  );

  // named per-line events
  assign over_ev  = loop_en && line_done && is_over;
  assign clean_ev = loop_en && line_done && is_clean;

  vagc_holdoff #(.DLY_W(DLY_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (!loop_en || over_ev),
    .clean_line (clean_ev),
    .delay      (rise_delay),
    .rise_ok    (rise_ev),
    .waiting    (hold_ev),
    .count      (hold_cnt)
  );

  vagc_gain_reg u_gain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_man (!loop_en),
    .man_gain ({man_coarse, man_fine}),
    .cut      (over_ev),
    .rise     (rise_ev),
    .step     (rise_step),
    .gain     (gain_now)
  );

  assign gain_coarse = gain_now[GAIN_W-1:FINE_W];
  assign gain_fine   = gain_now[FINE_W-1:0];
endmodule

// File: rtl/vagc_loop_chk.sv
module vagc_loop_chk
  import vagc_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                loop_en,
  input logic                line_done,
  input logic [NREF-1:0]     ref_mask,
  input logic [FINE_W-1:0]   rise_step,
  input logic [COARSE_W-1:0] man_coarse,
  input logic [FINE_W-1:0]   man_fine,
  input logic [COARSE_W-1:0] gain_coarse,
  input logic [FINE_W-1:0]   gain_fine,
  input logic                over_ev,
  input logic                rise_ev,
  input logic                hold_ev
);
  logic [GAIN_W-1:0] g;
  assign g = {gain_coarse, gain_fine};

  // R1
  always_comb if (!rst_n) a_r1_reset_min: assert (g == '0);

  a_r2_manual: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> g == {$past(man_coarse), $past(man_fine)});

  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !line_done) |=> $stable(g));

  a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(over_ev && rise_ev));

  a_r5_cut_drops: assert property (@(posedge clk) disable iff (!rst_n)
    over_ev |=> (g < $past(g)) || (g == '0));

  a_r6_hold_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ev |=> $stable(g));

  a_r7_rise_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> ({1'b0, g} >= {1'b0, $past(g)}) &&
                ({1'b0, g} <= {1'b0, $past(g)} + {{(GAIN_W+1-FINE_W){1'b0}}, $past(rise_step)}));

  a_r8_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && line_done && ref_mask == '0) |=> $stable(g));
endmodule

bind vagc_loop vagc_loop_chk #(.DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .loop_en     (loop_en),
  .line_done   (line_done),
  .ref_mask    (ref_mask),
  .rise_step   (rise_step),
  .man_coarse  (man_coarse),
  .man_fine    (man_fine),
  .gain_coarse (gain_coarse),
  .gain_fine   (gain_fine),
  .over_ev     (over_ev),
  .rise_ev     (rise_ev),
  .hold_ev     (hold_ev)
);

// File: tb/sim_vagc_loop.sv
`timescale 1ns/1ps
module sim_vagc_loop;
  logic clk = 0;
  logic rst_n = 0;
  logic loop_en = 0, line_done = 0, probe = 0;
  logic [3:0]  ref_mask = 4'hF;
  logic [9:0]  m_s = 0, m_b = 0, m_c = 0, m_l = 0;
  logic [9:0]  l_s = 500, l_b = 500, l_c = 500, l_l = 500;
  logic [11:0] step = 12'h100;
  logic [7:0]  dly = 8'd2;
  logic [3:0]  mc = 0;
  logic [11:0] mf = 0;
  logic [3:0]  gc;
  logic [11:0] gf;

  int errors = 0, checks = 0;
  int mgain = 0, mcnt = 0;
  logic [15:0] exp_v[$];
  string exp_t[$];

  always #5 clk = ~clk;

  vagc_loop u0 (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .line_done(line_done),
    .ref_mask(ref_mask),
    .meas_sync(m_s), .meas_burst(m_b), .meas_cpeak(m_c), .meas_lpeak(m_l),
    .lim_sync(l_s), .lim_burst(l_b), .lim_cpeak(l_c), .lim_lpeak(l_l),
    .rise_step(step), .rise_delay(dly), .man_coarse(mc), .man_fine(mf),
    .gain_coarse(gc), .gain_fine(gf)
  );

  // reference model, one clock edge
  task automatic model_edge();
    bit ovl;
    if (!loop_en) begin
      mgain = {mc, mf};
      mcnt = 0;
    end else if (line_done && ref_mask != 0) begin
      ovl = (ref_mask[0] && m_s > l_s) || (ref_mask[1] && m_b > l_b) ||
            (ref_mask[2] && m_c > l_c) || (ref_mask[3] && m_l > l_l);
      if (ovl) begin
        mgain = (mgain < 4096) ? 0 : mgain - 4096;
        mcnt = 0;
      end else if (mcnt >= dly) begin
        mgain = mgain + step;
        if (mgain > 65535) mgain = 65535;
      end else begin
        mcnt++;
      end
    end
  endtask

  // driver: one cycle, optionally a line strobe, optionally a check
  task automatic cyc(input bit ln, input bit chk, input string tag);
    line_done = ln;
    probe = chk;
    model_edge();
    if (chk) begin
      exp_v.push_back(16'(mgain));
      exp_t.push_back(tag);
    end
    @(posedge clk);
    @(negedge clk);
    line_done = 0;
    probe = 0;
  endtask

  task automatic set_meas(input int s, input int b, input int c, input int l);
    m_s = 10'(s); m_b = 10'(b); m_c = 10'(c); m_l = 10'(l);
  endtask

  // monitor: compare one negedge after each probed edge
  initial forever begin
    @(posedge clk);
    if (probe) begin
      @(negedge clk);
      if (exp_v.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_v.pop_front();
        t = exp_t.pop_front();
        checks++;
        if ({gc, gf} !== e) begin
          errors++;
          $display("FAIL %s: gain=%h expected=%h", t, {gc, gf}, e);
        end
      end
    end
  end

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    checks++;  // R1
    if ({gc, gf} !== 16'h0000) begin
      errors++;
      $display("FAIL R1: gain=%h expected=0000", {gc, gf});
    end
    rst_n = 1;
    @(negedge clk);

    // R2 manual path
    mc = 4'h5; mf = 12'h123;
    cyc(0, 1, "R2 manual");
    set_meas(100, 100, 100, 100);
    loop_en = 1;
    // R6 hold-off of 2 clean lines, then R7 raises
    cyc(1, 1, "R6 hold 1");
    cyc(1, 1, "R6 hold 2");
    cyc(1, 1, "R7 first raise");
    cyc(1, 1, "R7 second raise");
    // R3 no strobe, no change
    cyc(0, 0, "");
    cyc(0, 1, "R3 idle");
    // R5 overload on composite peak
    set_meas(100, 100, 600, 100);
    cyc(1, 1, "R5 cut");
    set_meas(100, 100, 100, 100);
    cyc(1, 1, "R6 hold after cut");
    // R4 luma peak masked off: clean
    ref_mask = 4'b0111;
    set_meas(100, 100, 100, 900);
    cyc(1, 1, "R4 masked ref ignored");
    cyc(1, 1, "R4 masked ref raise");
    // R4 only luma peak selected: overload
    ref_mask = 4'b1000;
    cyc(1, 1, "R4 selected ref cuts");
    // R4 equal to limit is not overload
    ref_mask = 4'b0001;
    set_meas(500, 900, 900, 900);
    cyc(1, 1, "R4 equal limit clean");
    // R8 mask zero
    ref_mask = 4'b0000;
    set_meas(900, 900, 900, 900);
    cyc(1, 1, "R8 mask zero");
    ref_mask = 4'hF;
    set_meas(100, 100, 100, 100);
    cyc(1, 1, "R8 counter unchanged");

    // R7 carry fine -> coarse
    loop_en = 0; mc = 4'h2; mf = 12'hF80; dly = 0;
    cyc(0, 1, "R2 manual reload");
    loop_en = 1;
    cyc(1, 1, "R7 carry");
    // R7 top saturation
    loop_en = 0; mc = 4'hF; mf = 12'hF80; step = 12'h0FF;
    cyc(0, 0, "");
    loop_en = 1;
    cyc(1, 1, "R7 saturate");
    cyc(1, 1, "R7 stay at top");
    // R5 bottom saturation
    loop_en = 0; mc = 4'h0; mf = 12'h800;
    cyc(0, 0, "");
    loop_en = 1;
    set_meas(700, 100, 100, 100);
    cyc(1, 1, "R5 floor");
    cyc(1, 1, "R5 stay at floor");

    cyc(0, 0, "");
    cyc(0, 0, "");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule